// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Configuration Aliases

This block is a bank of general-purpose I/O lines placed behind a small register bus. Software reads the synchronized input levels and drives the output data and per-line output enables. It also configures a per-line interrupt that is either edge-triggered or level-triggered, with a selectable polarity. Every configuration field has two write addresses. One sets the bits written as one and the other clears them, so software never needs a read-modify-write sequence.

The output data can be written in full. It can also be written through a masked window, where the address carries a bit mask and only the selected bits take the written value. Pending interrupt bits are readable and are cleared by writing ones. Pending bits are recorded even on disabled lines. The single interrupt output ORs together every line that is both pending and enabled.

Register select (when `addr[NL]` is 0) uses `addr[3:0]`:

| Select | Function |
|---|---|
| 0 | input levels (read) |
| 1 | output data |
| 2 / 3 | output enable, set / clear |
| 4 / 5 | trigger type, set / clear |
| 6 / 7 | polarity, set / clear |
| 8 / 9 | interrupt enable, set / clear |
| 10 | pending status (read, write-one-to-clear) |

Reads of a set or clear address return the field's current value. Any other select reads as zero. When `addr[NL]` is 1, the access goes to the masked output-data window with mask `addr[NL-1:0]`, and a read there returns the output data.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, the output data, output enable, trigger type, polarity and interrupt enable are all zero, so `pin_out`, `pin_oe` and `irq` are 0.
- R2: A read of select 0 returns `pin_in` as sampled through a two-flop synchronizer, so a change on `pin_in` is visible three clocks later at the latest.
- R3: A write to select 1 replaces the output data, which drives `pin_out`, and a read of select 1 returns it.
- R4: A write with `addr[NL]`=1 updates only the output bits whose mask bit `addr[NL-1:0]` is one, taking them from `wdata`. A zero mask changes nothing.
- R5: Writing select 2 sets, and select 3 clears, the output-enable bits given as ones in `wdata`. Bits written as zero keep their value.
- R6: Selects 4/5 set and clear the type bits (1 = edge, 0 = level), and selects 6/7 set and clear the polarity bits (1 = rising or high, 0 = falling or low). Both fields read back through their set address.
- R7: On an edge-type line with polarity 1, a rising synchronized input sets the pending bit, which stays set after the input falls again.
- R8: On an edge-type line with polarity 0, only a falling synchronized input sets the pending bit.
- R9: Writing ones to select 10 clears the matching edge-mode pending bits and leaves the other bits alone.
- R10: On a level-type line, the pending bit follows the active level (high when polarity is 1, low when polarity is 0). A clear does not remove it while that level holds.
- R11: Pending bits are set regardless of interrupt enable. `irq` is the OR of pending AND enabled, and selects 8/9 set and clear the enable bits.
- R12: When a new edge and a clear of the same bit land in the same cycle, the bit stays pending.
- R13: `ready` is high in the cycle after each cycle in which `req` is high, and `rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req | input | 1 | bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | NL+1 | register select, or mask window with mask |
| wdata | input | NL | write data |
| rdata | output | NL | read data, valid with ready |
| ready | output | 1 | access completed |
| pin_in | input | NL | asynchronous input lines |
| pin_out | output | NL | output data |
| pin_oe | output | NL | output driver enables |
| irq | output | 1 | combined bank interrupt |

## Verification
The bench builds the block with `NL` = 16. At that width the mask window spans the whole bank, and the full 16-bit patterns reach both the top line and the lowest line. One bank mixes edge-rising, edge-falling, level-low and level-high lines, so each trigger combination is observed next to the others in the same status word. The bench times the same-cycle edge-and-clear race from the synchronizer depth, which is fixed rather than parameterised.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int NL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [NL:0]   addr,
  input  logic [NL-1:0] wdata,
  output logic [NL-1:0] rdata,
  output logic          ready,
  input  logic [NL-1:0] pin_in,
  output logic [NL-1:0] pin_out,
  output logic [NL-1:0] pin_oe,
  output logic          irq
);
  logic [NL-1:0] s1, s2, s3, dout, oe, typ, pol, ie, st;

  wire            wr      = req & we;
  wire            mwr     = wr & addr[NL];
  wire            rwr     = wr & ~addr[NL];
  wire [3:0]      sel     = addr[3:0];
  wire [NL-1:0]   mask    = addr[NL-1:0];
  wire [NL-1:0]   clr_w   = (rwr && sel == 4'd10) ? wdata : '0;
  wire [NL-1:0]   lvl_act = (pol & s2) | (~pol & ~s2);
  wire [NL-1:0]   edge_hit = typ & ((pol & s2 & ~s3) | (~pol & ~s2 & s3));
  wire [NL-1:0]   st_nx   = (typ & st & ~clr_w) | edge_hit | (~typ & lvl_act);

  assign pin_out = dout;
  assign pin_oe  = oe;
  assign irq     = |(st & ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3, dout, oe, typ, pol, ie, st} <= '0;
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      st <= st_nx;
      ready <= req;
      if (mwr) dout <= (dout & ~mask) | (wdata & mask);
      if (rwr) begin
        case (sel)
          4'd1: dout <= wdata;
          4'd2: oe   <= oe | wdata;
          4'd3: oe   <= oe & ~wdata;
          4'd4: typ  <= typ | wdata;
          4'd5: typ  <= typ & ~wdata;
          4'd6: pol  <= pol | wdata;
          4'd7: pol  <= pol & ~wdata;
          4'd8: ie   <= ie | wdata;
          4'd9: ie   <= ie & ~wdata;
          default: ;
        endcase
      end
      if (req) begin
        if (addr[NL]) rdata <= dout;
        else begin
          case (sel)
            4'd0:       rdata <= s2;
            4'd1:       rdata <= dout;
            4'd2, 4'd3: rdata <= oe;
            4'd4, 4'd5: rdata <= typ;
            4'd6, 4'd7: rdata <= pol;
            4'd8, 4'd9: rdata <= ie;
            4'd10:      rdata <= st;
            default:    rdata <= '0;
          endcase
        end
      end
    end
  end

  p_ready_follows_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ready);

  p_mask_keeps_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mwr |=> (dout & ~$past(mask)) == ($past(dout) & ~$past(mask)));

  p_oe_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rwr && sel == 4'd3) |=> (oe & $past(wdata)) == '0);

  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (st & $past(st & typ & ~clr_w)) == $past(st & typ & ~clr_w));

  p_level_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((st ^ $past(lvl_act)) & $past(~typ)) == '0);

  p_edge_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (st & $past(edge_hit)) == $past(edge_hit));
endmodule

// File: tb/sim_gpio_setclr_bank.sv
module sim_gpio_setclr_bank;
  localparam int NL = 16;
  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [NL:0] addr = '0;
  logic [NL-1:0] wdata = '0, pin_in = '0;
  logic [NL-1:0] rdata, pin_out, pin_oe;
  logic ready, irq;
  int n_chk = 0, n_fail = 0;
  logic [NL-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  gpio_setclr_bank #(.NL(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string tag, logic [NL-1:0] got, logic [NL-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk)
    if (ready && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic wr(logic [NL:0] a, logic [NL-1:0] d);
    addr = a; wdata = d; we = 1; req = 1;
    @(negedge clk); req = 0; we = 0;
    @(negedge clk);
  endtask

  task automatic rd(logic [NL:0] a, logic [NL-1:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; we = 0; req = 1;
    @(negedge clk); req = 0;
    @(negedge clk);
  endtask

  task automatic settle(logic [NL-1:0] p);
    pin_in = p;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {15'd0, irq}, '0);
    rd(17'd4, 16'h0000, "R1 type");
    rd(17'd10, 16'hFFFF, "R10 level-low after reset");
    settle(16'hA5C3);
    rd(17'd0, 16'hA5C3, "R2 input");
    rd(17'd10, 16'h5A3C, "R10 follow input");
    wr(17'd1, 16'h1234);
    chk("R3 pin_out", pin_out, 16'h1234);
    rd(17'd1, 16'h1234, "R3 readback");
    wr({1'b1, 16'h00FF}, 16'hABCD);
    chk("R4 masked", pin_out, 16'h12CD);
    wr({1'b1, 16'h0000}, 16'hFFFF);
    chk("R4 zero mask", pin_out, 16'h12CD);
    wr(17'd2, 16'h00F0);
    chk("R5 set", pin_oe, 16'h00F0);
    wr(17'd2, 16'h0F00);
    chk("R5 set keeps", pin_oe, 16'h0FF0);
    wr(17'd3, 16'h0030);
    chk("R5 clear", pin_oe, 16'h0FC0);
    wr(17'd4, 16'h0003);
    wr(17'd6, 16'h0001);
    wr(17'd7, 16'h0000);
    rd(17'd5, 16'h0003, "R6 type");
    rd(17'd6, 16'h0001, "R6 polarity");
    settle(16'h0000);
    wr(17'd10, 16'h0003);
    rd(17'd10, 16'hFFFC, "R9 clear edge bits");
    settle(16'h0001);
    settle(16'h0000);
    rd(17'd10, 16'hFFFD, "R7 rising sticky");
    settle(16'h0002);
    rd(17'd10, 16'hFFFD, "R8 rise ignored");
    settle(16'h0000);
    rd(17'd10, 16'hFFFF, "R8 falling sets");
    wr(17'd10, 16'h0001);
    rd(17'd10, 16'hFFFE, "R9 clear one bit");
    chk("R11 irq masked", {15'd0, irq}, '0);
    wr(17'd8, 16'h0002);
    chk("R11 irq enabled", {15'd0, irq}, 16'h0001);
    wr(17'd9, 16'h0002);
    chk("R11 irq disabled", {15'd0, irq}, '0);
    wr(17'd8, 16'h0001);
    chk("R11 enabled not pending", {15'd0, irq}, '0);
    wr(17'd6, 16'h0010);
    rd(17'd10, 16'hFFEE, "R10 level-high inactive");
    wr(17'd10, 16'h0004);
    rd(17'd10, 16'hFFEE, "R10 clear while active");
    settle(16'h0010);
    rd(17'd10, 16'hFFFE, "R10 level-high active");
    settle(16'h0011);
    chk("R11 irq on edge", {15'd0, irq}, 16'h0001);
    settle(16'h0010);
    pin_in = 16'h0011;
    @(negedge clk); @(negedge clk);
    addr = 17'd10; wdata = 16'h0001; we = 1; req = 1;
    @(negedge clk); req = 0; we = 0;
    @(negedge clk);
    rd(17'd10, 16'hFFFF, "R12 edge beats clear");
    wr(17'd10, 16'h0001);
    rd(17'd10, 16'hFFFE, "R12 later clear works");
    addr = 17'd0; req = 1;
    @(negedge clk); req = 0;
    chk("R13 ready", {15'd0, ready}, 16'h0001);
    @(negedge clk);
    chk("R13 ready drops", {15'd0, ready}, '0);
    repeat (2) @(negedge clk);
    chk("queue drained", exp_q.size(), '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule